// File: doc/BRIEF.md
# Serial Flash Controller Interrupt Logic

This block produces the single interrupt request of a quad-SPI flash controller. The transfer engine sends it two kinds of completion pulse, one per word moved and one per finished frame. Each pulse sets a sticky flag. A flag raises the interrupt line only while its mask bit is on. Software reaches the flags and masks through two register views that share the same state. The first is a command/status pair, where a command write or a status read clears both flags. The second is a set/clear group made of a raw status that can be forced by software, an enabled status with write-one-to-clear, and separate enable-set and enable-clear registers.

A mode register holds a gate for word-complete interrupts while the memory-mapped port is running transfers. The `mm_active` input tells the block when that port is busy. Frame-complete interrupts are never gated. The register port is simple. `rdata` follows `addr` combinationally at all times. Read side effects happen only when `rd_en` is high.

Top module: `sflash_irq_ctrl`

## Requirements
- R1: An `evt_word` pulse sets the word flag and an `evt_frame` pulse sets the frame flag. Both flags stay set until cleared. The status register at address 1 shows the word flag on bit 1 and the frame flag on bit 2.
- R2: The raw status register at address 3 shows the word flag on bit 1 and the frame flag on bit 0. Writing 1 to a bit sets that flag. Writing 0 leaves it unchanged.
- R3: The enabled status register at address 4 reads flag AND mask, with word on bit 1 and frame on bit 0. Writing 1 to a bit clears that flag. Writing 0 leaves it unchanged.
- R4: Writing 1 to bit 1 (word) or bit 0 (frame) of address 5 turns that mask bit on. Writing 1 to the same bits of address 6 turns the mask bit off. Zeros do nothing. Reading either address returns the mask.
- R5: The command register at address 0 holds the word mask in bit 14 and the frame mask in bit 15. These are the same mask bits as in R4. Any write to address 0 clears both flags.
- R6: A read strobe (`rd_en`) at address 1 clears both flags after the read data is returned.
- R7: An event pulse in the same cycle as a clearing access leaves its flag set.
- R8: `irq` is a register equal to the OR of (flag AND mask) for the two events, taken on the previous clock edge. It rises one cycle after a masked flag is set and falls one cycle after the last enabled flag is cleared.
- R9: The mode register sits at address 2. While `mm_active` is high and bit 1 of that register is 0, the word flag does not drive `irq`. With bit 1 at 1, or with `mm_active` low, the word flag drives `irq` normally. The frame path is never gated.
- R10: After reset all flags, masks and the mode bit are 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_word | input | 1 | Word-complete pulse from the transfer engine |
| evt_frame | input | 1 | Frame-complete pulse from the transfer engine |
| mm_active | input | 1 | Memory-mapped port is running transfers |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (enables read side effects) |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest cases to reach are collisions, where a completion pulse lands in the same cycle as a command write, a status read strobe or a write-one-to-clear. The stimulus drives these on purpose in each combination and then reads the raw status without a read strobe, so the read itself does not disturb the flags. Word-complete gating is reached by holding `mm_active` high with the mode bit off while a masked word flag is pending. The stimulus then toggles the mode bit and `mm_active` to show the line following both. A pseudo-random phase after these cases mixes all accesses, and a behavioural model checks every cycle.

// File: rtl/sflash_irq_ctrl.sv
module sflash_irq_ctrl #(
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_word,
  input  logic          evt_frame,
  input  logic          mm_active,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam logic [AW-1:0] A_CMD  = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_MODE = AW'(2);
  localparam logic [AW-1:0] A_RAW  = AW'(3);
  localparam logic [AW-1:0] A_ENA  = AW'(4);
  localparam logic [AW-1:0] A_MSET = AW'(5);
  localparam logic [AW-1:0] A_MCLR = AW'(6);

  logic word_flag, frame_flag, word_mask, frame_mask, mm_word_en, irq_q;

  wire cmd_wr   = wr_en && addr == A_CMD;
  wire stat_rd  = rd_en && addr == A_STAT;
  wire grp_clr  = cmd_wr || stat_rd;
  wire set_w    = evt_word  || (wr_en && addr == A_RAW && wdata[1]);
  wire set_f    = evt_frame || (wr_en && addr == A_RAW && wdata[0]);
  wire clr_w    = grp_clr || (wr_en && addr == A_ENA && wdata[1]);
  wire clr_f    = grp_clr || (wr_en && addr == A_ENA && wdata[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_flag  <= 1'b0;
      frame_flag <= 1'b0;
    end else begin
      if (set_w)      word_flag  <= 1'b1;
      else if (clr_w) word_flag  <= 1'b0;
      if (set_f)      frame_flag <= 1'b1;
      else if (clr_f) frame_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_mask  <= 1'b0;
      frame_mask <= 1'b0;
      mm_word_en <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_CMD:  begin word_mask <= wdata[14]; frame_mask <= wdata[15]; end
        A_MODE: mm_word_en <= wdata[1];
        A_MSET: begin
          if (wdata[1]) word_mask  <= 1'b1;
          if (wdata[0]) frame_mask <= 1'b1;
        end
        A_MCLR: begin
          if (wdata[1]) word_mask  <= 1'b0;
          if (wdata[0]) frame_mask <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  wire word_req  = word_flag && word_mask && (!mm_active || mm_word_en);
  wire frame_req = frame_flag && frame_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= word_req || frame_req;
  end

  assign irq = irq_q;

  always_comb begin
    rdata = '0;
    case (addr)
      A_CMD:  begin rdata[14] = word_mask; rdata[15] = frame_mask; end
      A_STAT: begin rdata[1] = word_flag; rdata[2] = frame_flag; end
      A_MODE: rdata[1] = mm_word_en;
      A_RAW:  begin rdata[1] = word_flag; rdata[0] = frame_flag; end
      A_ENA:  begin rdata[1] = word_flag && word_mask; rdata[0] = frame_flag && frame_mask; end
      A_MSET, A_MCLR: begin rdata[1] = word_mask; rdata[0] = frame_mask; end
      default: ;
    endcase
  end
endmodule

module sflash_irq_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          evt_word,
  input logic          evt_frame,
  input logic          mm_active,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic          word_flag,
  input logic          frame_flag,
  input logic          word_mask,
  input logic          frame_mask,
  input logic          mm_word_en,
  input logic          irq
);
  p_word_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_word |=> word_flag);

  p_frame_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_frame |=> frame_flag);

  p_evt_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_frame && ((wr_en && addr == AW'(0)) || (rd_en && addr == AW'(1)))) |=> frame_flag);

  p_rd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(1) && !evt_word && !wr_en) |=> !word_flag);

  p_no_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_mask && !frame_mask) |=> !irq);

  p_mm_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_active && !mm_word_en && !(frame_flag && frame_mask)) |=> !irq);
endmodule

bind sflash_irq_ctrl sflash_irq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_word(evt_word), .evt_frame(evt_frame),
  .mm_active(mm_active), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .word_flag(word_flag), .frame_flag(frame_flag), .word_mask(word_mask),
  .frame_mask(frame_mask), .mm_word_en(mm_word_en), .irq(irq)
);

// File: tb/sim_sflash_irq_ctrl.sv
`timescale 1ns/1ps
module sim_sflash_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_word = 0, evt_frame = 0, mm_active = 0, wr_en = 0, rd_en = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sflash_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .evt_word(evt_word), .evt_frame(evt_frame),
    .mm_active(mm_active), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq));

  // behavioural reference model
  bit m_wf, m_ff, m_wm, m_fm, m_sw, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wf <= 0; m_ff <= 0; m_wm <= 0; m_fm <= 0; m_sw <= 0; m_irq <= 0;
    end else begin
      bit clr_all;
      clr_all = (wr_en && addr == 0) || (rd_en && addr == 1);
      m_irq <= (m_wf && m_wm && (!mm_active || m_sw)) || (m_ff && m_fm);
      if (evt_word || (wr_en && addr == 3 && wdata[1])) m_wf <= 1;
      else if (clr_all || (wr_en && addr == 4 && wdata[1])) m_wf <= 0;
      if (evt_frame || (wr_en && addr == 3 && wdata[0])) m_ff <= 1;
      else if (clr_all || (wr_en && addr == 4 && wdata[0])) m_ff <= 0;
      if (wr_en) begin
        if (addr == 0) begin m_wm <= wdata[14]; m_fm <= wdata[15]; end
        if (addr == 2) m_sw <= wdata[1];
        if (addr == 5) begin if (wdata[1]) m_wm <= 1; if (wdata[0]) m_fm <= 1; end
        if (addr == 6) begin if (wdata[1]) m_wm <= 0; if (wdata[0]) m_fm <= 0; end
      end
    end
  end

  function automatic logic [31:0] model_rd(input logic [2:0] a);
    logic [31:0] v = 0;
    case (a)
      0: begin v[14] = m_wm; v[15] = m_fm; end
      1: begin v[1] = m_wf; v[2] = m_ff; end
      2: v[1] = m_sw;
      3: begin v[1] = m_wf; v[0] = m_ff; end
      4: begin v[1] = m_wf & m_wm; v[0] = m_ff & m_fm; end
      5, 6: begin v[1] = m_wm; v[0] = m_fm; end
      default: ;
    endcase
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      chk("R8 irq vs model", {31'b0, irq}, {31'b0, m_irq});
      chk("R1-model rdata", rdata, model_rd(addr));
    end
  end

  task automatic cyc(input bit ew, input bit ef, input bit mm, input bit wr, input bit rd,
                     input logic [2:0] a, input logic [31:0] d);
    evt_word = ew; evt_frame = ef; mm_active = mm; wr_en = wr; rd_en = rd; addr = a; wdata = d;
    @(negedge clk);
    evt_word = 0; evt_frame = 0; wr_en = 0; rd_en = 0;
  endtask

  task automatic peek(input logic [2:0] a, input string tag, input logic [31:0] exp);
    addr = a; #1; chk(tag, rdata, exp);
  endtask

  task automatic idle(input bit mm); cyc(0, 0, mm, 0, 0, 3'd7, 0); endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R10 irq after reset", {31'b0, irq}, 0);
    peek(1, "R10 status after reset", 0);
    peek(5, "R10 mask after reset", 0);
    rst_n = 1;
    @(negedge clk);

    cyc(1, 0, 0, 0, 0, 3'd7, 0);
    peek(1, "R1 word flag in status bit1", 32'h2);
    cyc(0, 1, 0, 0, 0, 3'd7, 0);
    peek(1, "R1 both flags in status", 32'h6);
    peek(3, "R2 raw shows both", 32'h3);
    idle(0);
    chk("R8 no irq while masked", {31'b0, irq}, 0);

    cyc(0, 0, 0, 1, 0, 3'd5, 32'h2);
    peek(5, "R4 set word mask read via set reg", 32'h2);
    peek(6, "R4 mask read via clear reg", 32'h2);
    peek(0, "R5 cmd bit14 shows word mask", 32'h4000);
    chk("R8 irq not yet on mask edge", {31'b0, irq}, 0);
    idle(0);
    chk("R8 irq one cycle after mask", {31'b0, irq}, 1);
    peek(4, "R3 enabled status", 32'h2);

    cyc(0, 0, 0, 1, 0, 3'd4, 32'h1);
    peek(3, "R3 w1c frame flag", 32'h2);
    cyc(0, 0, 0, 1, 0, 3'd4, 32'h0);
    peek(3, "R3 write zero no effect", 32'h2);
    cyc(0, 0, 0, 1, 0, 3'd4, 32'h2);
    peek(3, "R3 w1c word flag", 32'h0);
    chk("R8 irq held on clear edge", {31'b0, irq}, 1);
    idle(0);
    chk("R8 irq drops one cycle later", {31'b0, irq}, 0);

    cyc(0, 0, 0, 1, 0, 3'd3, 32'h0);
    peek(3, "R2 raw write zero no effect", 32'h0);
    cyc(0, 0, 0, 1, 0, 3'd3, 32'h1);
    peek(3, "R2 raw write one sets frame", 32'h1);
    cyc(0, 0, 0, 1, 0, 3'd3, 32'h2);
    cyc(0, 0, 0, 0, 1, 3'd1, 0);
    peek(3, "R6 status read clears", 32'h0);

    cyc(0, 0, 0, 1, 0, 3'd6, 32'h2);
    peek(6, "R4 clear word mask", 32'h0);

    cyc(1, 1, 0, 0, 0, 3'd7, 0);
    cyc(0, 1, 0, 1, 0, 3'd0, 32'h0000C000);
    peek(3, "R7 frame event beats cmd write; R5 word cleared", 32'h1);
    peek(5, "R5 cmd write sets both masks", 32'h3);
    cyc(1, 0, 0, 0, 1, 3'd1, 0);
    peek(3, "R7 word event beats status read", 32'h2);
    cyc(0, 1, 0, 1, 0, 3'd4, 32'h1);
    peek(3, "R7 frame event beats w1c", 32'h3);

    cyc(0, 0, 0, 1, 0, 3'd0, 32'h00004000);
    cyc(1, 0, 1, 0, 0, 3'd7, 0);
    idle(1); idle(1);
    chk("R9 word irq gated in mapped mode", {31'b0, irq}, 0);
    idle(0);
    chk("R9 word irq when mapped mode off", {31'b0, irq}, 1);
    cyc(0, 0, 1, 1, 0, 3'd2, 32'h2);
    peek(2, "R9 mode bit readback", 32'h2);
    idle(1);
    chk("R9 word irq with mode bit on", {31'b0, irq}, 1);
    cyc(0, 0, 1, 1, 0, 3'd2, 32'h0);
    idle(1);
    chk("R9 gated again", {31'b0, irq}, 0);
    cyc(0, 0, 1, 1, 0, 3'd5, 32'h1);
    cyc(0, 1, 1, 0, 0, 3'd7, 0);
    idle(1);
    chk("R9 frame path never gated", {31'b0, irq}, 1);

    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        cyc(lf[0] & lf[5], lf[1] & lf[6], lf[2], lf[3] & lf[7], lf[4] & lf[8], lf[11:9],
            {16'b0, lf[14], lf[15], 12'b0, lf[12], lf[13]});
      end
    end
    idle(0);
    finish_run();
  end
endmodule